// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small 8-bit processor built around a single accumulator. It runs every instruction as an explicit series of register transfers. An instruction fetch copies the program counter into a memory address register, then reads memory into a memory data register, then moves that word into an instruction register. A decode step follows, and then a short execute phase. The upper four bits of each instruction select the operation. The lower four bits name the memory word that the operation works on.

The processor has four operations: load a word into the accumulator, add a word to it, store it to memory, and halt. Any other opcode does nothing and the program moves on. The memory is a 16-word by 8-bit synchronous array inside the block. A read returns its data one cycle after it is issued.

While reset is held, a preload port writes the program and data into the memory. A monitor port reads any word back without waiting. The address, read strobe, write strobe and write data that the processor drives are brought out as outputs, so the memory traffic can be watched.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is asserted, `pc_o`, `acc_o`, `carry_o` and `halted_o` are 0. The first memory read after reset is released is issued to address 0.
- R2: A fetch takes four cycles: address setup, read, data capture and instruction load. Its read is issued with `mem_addr_o` equal to `pc_o`.
- R3: `pc_o` changes only by adding 1. It advances once per instruction, on the edge that ends the fourth fetch cycle.
- R4: Instruction bits [7:4] are the opcode and bits [3:0] are the memory address that the operation uses.
- R5: Opcode 4'b0101 (load) copies the word at the operand address into the accumulator and leaves the carry flag unchanged.
- R6: Opcode 4'b0010 (add) sets the accumulator to (accumulator + word) mod 256 and sets the carry flag to the carry-out of that sum.
- R7: Opcode 4'b0011 (store) writes the accumulator to the operand address with one write strobe, and the accumulator keeps its value.
- R8: Opcode 4'b1111 (halt) raises `halted_o` for good. After that the core issues no memory read or write and `pc_o` stays fixed until the next reset.
- R9: Any other opcode changes nothing except the program counter: the accumulator, the carry flag and memory keep their values.
- R10: A memory read returns its data one cycle after it is issued. Counted from the cycle after reset is released, the instruction lengths are load 8, add 8, store 6, other opcodes 5, and halt reaches its halted state after 5 cycles.
- R11: A write on the preload port updates the addressed memory word. `mon_rdata_o` shows the word at `mon_addr` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 4 | Preload word address |
| pl_wdata | input | 8 | Preload word value |
| mon_addr | input | 4 | Monitor read address |
| mon_rdata_o | output | 8 | Word stored at `mon_addr` |
| mem_addr_o | output | 4 | Address the core drives to memory (the memory address register) |
| mem_rd_o | output | 1 | Core read strobe |
| mem_wr_o | output | 1 | Core write strobe |
| mem_wdata_o | output | 8 | Core write data |
| pc_o | output | 4 | Program counter |
| acc_o | output | 8 | Accumulator |
| carry_o | output | 1 | Carry flag from the last add |
| halted_o | output | 1 | High once a halt has executed |

## Verification
Some properties are checked on every cycle by assertions. The program counter only ever moves up by one, and it does so right after an instruction load. Each data capture follows a read strobe from the cycle before. Every fetch read is addressed by the program counter. Every store write targets the operand of the current instruction. Each add leaves the 9-bit sum of the previous accumulator and the captured word. After a halt, memory traffic and the program counter stay frozen.

Other behaviour can only be shown by the bench scenarios. These cover the reset values, the exact instruction lengths, and the final memory contents from the load-add-store program over several operand pairs, including wrap-around sums. They also show that the carry flag survives a later load, and that a no-op opcode leaves the accumulator and memory untouched.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OP_W = 4;

   localparam logic [OP_W-1:0] OPC_LOAD  = 4'b0101;
   localparam logic [OP_W-1:0] OPC_ADD   = 4'b0010;
   localparam logic [OP_W-1:0] OPC_STORE = 4'b0011;
   localparam logic [OP_W-1:0] OPC_HALT  = 4'b1111;

   typedef enum logic [3:0] {
      ST_F_ADDR,
      ST_F_READ,
      ST_F_MDR,
      ST_F_IR,
      ST_DECODE,
      ST_X_READ,
      ST_X_MDR,
      ST_X_ACC,
      ST_X_WRITE,
      ST_HALT
   } phase_t;

   typedef enum logic [1:0] {
      ACC_KEEP,
      ACC_LOAD,
      ACC_SUM
   } acc_op_t;

   typedef struct packed {
      logic    mar_from_pc;
      logic    mar_from_ir;
      logic    mdr_ld;
      logic    ir_ld;
      logic    mem_rd;
      logic    mem_wr;
      acc_op_t acc_op;
   } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
   parameter int W     = 8,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic         cout
);

   generate
      if (STYLE == 0) begin : g_fast
         assign {cout, sum} = {1'b0, a} + {1'b0, b};
      end else begin : g_ripple
         logic [W:0] c;
         assign c[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]   = a[i] ^ b[i] ^ c[i];
            assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
         end
         assign cout = c[W];
      end
   endgenerate

endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rd,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              pl_we,
   input  logic [ADDR_W-1:0] pl_addr,
   input  logic [DATA_W-1:0] pl_wdata,
   input  logic [ADDR_W-1:0] mon_addr,
   output logic [DATA_W-1:0] mon_rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (pl_we) begin
         words[pl_addr] <= pl_wdata;
      end else if (wr) begin
         words[addr] <= wdata;
      end
      if (rd) begin
         rdata <= words[addr];
      end
   end

   assign mon_rdata = words[mon_addr];

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
   import acc_cpu_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] opcode,
   output ctrl_t           ctrl,
   output phase_t          phase,
   output logic            halted
);

   phase_t nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= ST_F_ADDR;
      end else begin
         phase <= nxt;
      end
   end

   always_comb begin
      nxt  = phase;
      ctrl = '0;
      unique case (phase)
         ST_F_ADDR: begin
            ctrl.mar_from_pc = 1'b1;
            nxt = ST_F_READ;
         end
         ST_F_READ: begin
            ctrl.mem_rd = 1'b1;
            nxt = ST_F_MDR;
         end
         ST_F_MDR: begin
            ctrl.mdr_ld = 1'b1;
            nxt = ST_F_IR;
         end
         ST_F_IR: begin
            ctrl.ir_ld = 1'b1;
            nxt = ST_DECODE;
         end
         ST_DECODE: begin
            if (opcode == OPC_LOAD || opcode == OPC_ADD) begin
               ctrl.mar_from_ir = 1'b1;
               nxt = ST_X_READ;
            end else if (opcode == OPC_STORE) begin
               ctrl.mar_from_ir = 1'b1;
               nxt = ST_X_WRITE;
            end else if (opcode == OPC_HALT) begin
               nxt = ST_HALT;
            end else begin
               nxt = ST_F_ADDR;
            end
         end
         ST_X_READ: begin
            ctrl.mem_rd = 1'b1;
            nxt = ST_X_MDR;
         end
         ST_X_MDR: begin
            ctrl.mdr_ld = 1'b1;
            nxt = ST_X_ACC;
         end
         ST_X_ACC: begin
            ctrl.acc_op = (opcode == OPC_ADD) ? ACC_SUM : ACC_LOAD;
            nxt = ST_F_ADDR;
         end
         ST_X_WRITE: begin
            ctrl.mem_wr = 1'b1;
            nxt = ST_F_ADDR;
         end
         ST_HALT: begin
            nxt = ST_HALT;
         end
         default: begin
            nxt = ST_F_ADDR;
         end
      endcase
   end

   assign halted = (phase == ST_HALT);

   // R8: once halted, stay halted with no memory traffic
   p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !ctrl.mem_rd && !ctrl.mem_wr));

   // R10: data capture always follows a read issued one cycle earlier
   p_capture_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.mdr_ld |-> $past(ctrl.mem_rd));

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int ADD_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctrl_t             ctrl,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] acc,
   output logic              carry,
   output logic [OP_W-1:0]   opcode,
   output logic [ADDR_W-1:0] operand
);

   localparam logic [ADDR_W-1:0] PC_ONE = 1;

   logic [DATA_W-1:0] mdr;
   logic [DATA_W-1:0] ir;
   logic [DATA_W-1:0] alu_sum;
   logic              alu_cout;

   assign opcode  = ir[DATA_W-1 -: OP_W];
   assign operand = ir[ADDR_W-1:0];

   acc_cpu_alu #(
      .W     (DATA_W),
      .STYLE (ADD_STYLE)
   ) alu_i (
      .a    (acc),
      .b    (mdr),
      .sum  (alu_sum),
      .cout (alu_cout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc    <= '0;
         mar   <= '0;
         mdr   <= '0;
         ir    <= '0;
         acc   <= '0;
         carry <= 1'b0;
      end else begin
         if (ctrl.mar_from_pc) begin
            mar <= pc;
         end else if (ctrl.mar_from_ir) begin
            mar <= operand;
         end
         if (ctrl.mdr_ld) begin
            mdr <= mem_rdata;
         end
         if (ctrl.ir_ld) begin
            ir <= mdr;
            pc <= pc + PC_ONE;
         end
         unique case (ctrl.acc_op)
            ACC_LOAD: acc <= mdr;
            ACC_SUM: begin
               acc   <= alu_sum;
               carry <= alu_cout;
            end
            default: ;
         endcase
      end
   end

   // R3: the program counter only ever steps up by one
   p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pc != $past(pc)) |-> (pc == $past(pc) + PC_ONE));

   // R3: each instruction load is followed by one increment
   p_pc_after_ir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.ir_ld |=> (pc == $past(pc) + PC_ONE));

   // R6: an add leaves the full 9-bit sum in carry and accumulator
   p_add_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.acc_op == ACC_SUM) |=>
         ({carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(mdr)})));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int ADD_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pl_we,
   input  logic [ADDR_W-1:0] pl_addr,
   input  logic [DATA_W-1:0] pl_wdata,
   input  logic [ADDR_W-1:0] mon_addr,
   output logic [DATA_W-1:0] mon_rdata_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] acc_o,
   output logic              carry_o,
   output logic              halted_o
);

   generate
      if (DATA_W - ADDR_W != OP_W) begin : g_bad_format
         $error("instruction word must hold a %0d-bit opcode above the address", OP_W);
      end
      if (ADD_STYLE != 0 && ADD_STYLE != 1) begin : g_bad_style
         $error("ADD_STYLE must be 0 (inferred) or 1 (ripple)");
      end
   endgenerate

   ctrl_t             ctrl;
   phase_t            phase;
   logic [OP_W-1:0]   opcode;
   logic [ADDR_W-1:0] operand;
   logic [ADDR_W-1:0] mar;
   logic [DATA_W-1:0] rdata;

   acc_cpu_seq seq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (opcode),
      .ctrl   (ctrl),
      .phase  (phase),
      .halted (halted_o)
   );

   acc_cpu_datapath #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .ADD_STYLE (ADD_STYLE)
   ) dp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl),
      .mem_rdata (rdata),
      .pc        (pc_o),
      .mar       (mar),
      .acc       (acc_o),
      .carry     (carry_o),
      .opcode    (opcode),
      .operand   (operand)
   );

   acc_cpu_mem #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) mem_i (
      .clk       (clk),
      .rd        (ctrl.mem_rd),
      .wr        (ctrl.mem_wr),
      .addr      (mar),
      .wdata     (acc_o),
      .rdata     (rdata),
      .pl_we     (pl_we),
      .pl_addr   (pl_addr),
      .pl_wdata  (pl_wdata),
      .mon_addr  (mon_addr),
      .mon_rdata (mon_rdata_o)
   );

   assign mem_addr_o  = mar;
   assign mem_rd_o    = ctrl.mem_rd;
   assign mem_wr_o    = ctrl.mem_wr;
   assign mem_wdata_o = acc_o;

   // R2: instruction reads are addressed by the program counter
   p_fetch_from_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_F_READ) |-> (mem_rd_o && mem_addr_o == pc_o));

   // R7: a store writes to the operand of the current instruction
   p_store_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> (mem_addr_o == operand && opcode == OPC_STORE));

   // R8: the program counter is frozen while halted
   p_halt_pc_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> $stable(pc_o));

endmodule

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;

   localparam int CLK_P   = 10;
   localparam int WD_MAX  = 100000;
   localparam int RUN_MAX = 300;

   // vector fields: a [24:17], b [16:9], expected sum [8:1], expected carry [0]
   localparam logic [24:0] VEC [6] = '{
      {8'h01, 8'h02, 8'h03, 1'b0},
      {8'hFF, 8'h01, 8'h00, 1'b1},
      {8'h80, 8'h80, 8'h00, 1'b1},
      {8'h7F, 8'h01, 8'h80, 1'b0},
      {8'h00, 8'h00, 8'h00, 1'b0},
      {8'hFE, 8'hFF, 8'hFD, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pl_we = 1'b0;
   logic [3:0] pl_addr = '0;
   logic [7:0] pl_wdata = '0;
   logic [3:0] mon_addr = '0;
   logic [7:0] mon_rdata_o;
   logic [3:0] mem_addr_o;
   logic       mem_rd_o;
   logic       mem_wr_o;
   logic [7:0] mem_wdata_o;
   logic [3:0] pc_o;
   logic [7:0] acc_o;
   logic       carry_o;
   logic       halted_o;

   logic [7:0] prog [16];
   int n_cmp = 0;
   int n_bad = 0;
   int wd_cnt = 0;

   acc_cpu_core dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pl_we       (pl_we),
      .pl_addr     (pl_addr),
      .pl_wdata    (pl_wdata),
      .mon_addr    (mon_addr),
      .mon_rdata_o (mon_rdata_o),
      .mem_addr_o  (mem_addr_o),
      .mem_rd_o    (mem_rd_o),
      .mem_wr_o    (mem_wr_o),
      .mem_wdata_o (mem_wdata_o),
      .pc_o        (pc_o),
      .acc_o       (acc_o),
      .carry_o     (carry_o),
      .halted_o    (halted_o)
   );

   always #(CLK_P / 2) clk = ~clk;

   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > WD_MAX) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<=%0d cycles", wd_cnt, WD_MAX);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic peek(input logic [3:0] a, output logic [7:0] v);
      mon_addr = a;
      #1;
      v = mon_rdata_o;
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 16; i++) prog[i] = 8'h00;
   endtask

   // hold reset, preload memory, check reset values, release at a negedge
   task automatic boot();
      logic [7:0] v;
      rst_n = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         pl_we    = 1'b1;
         pl_addr  = i[3:0];
         pl_wdata = prog[i];
         @(negedge clk);
      end
      pl_we = 1'b0;
      chk("R1 pc in reset", 32'(pc_o), 32'h0);
      chk("R1 acc in reset", 32'(acc_o), 32'h0);
      chk("R1 carry+halted in reset", {30'b0, carry_o, halted_o}, 32'h0);
      peek(4'h0, v);
      chk("R11 preload word 0", 32'(v), 32'(prog[0]));
      rst_n = 1'b1;
   endtask

   task automatic wait_halt(output int n);
      n = 0;
      while (!halted_o && n < RUN_MAX) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      int n;
      logic [7:0] v;

      // table walk: load a, add b, store sum to 6, halt
      for (int k = 0; k < 6; k++) begin
         clear_prog();
         prog[0] = 8'h54;
         prog[1] = 8'h25;
         prog[2] = 8'h36;
         prog[3] = 8'hF0;
         prog[4] = VEC[k][24:17];
         prog[5] = VEC[k][16:9];
         boot();
         wait_halt(n);
         chk($sformatf("R10 vec%0d cycles to halt", k), 32'(n), 32'd27);
         peek(4'h6, v);
         chk($sformatf("R6 R4 vec%0d stored sum", k), 32'(v), 32'(VEC[k][8:1]));
         chk($sformatf("R7 vec%0d acc after store", k), 32'(acc_o), 32'(VEC[k][8:1]));
         chk($sformatf("R6 vec%0d carry", k), 32'(carry_o), 32'(VEC[k][0]));
         chk($sformatf("R3 vec%0d final pc", k), 32'(pc_o), 32'd4);
      end

      // directed: fetch timing, load, store, no-op, halt
      clear_prog();
      prog[0]    = 8'h5E;
      prog[1]    = 8'h3F;
      prog[2]    = 8'h00;
      prog[3]    = 8'hF0;
      prog[4'hE] = 8'h5A;
      boot();
      chk("R1 no read at release", 32'(mem_rd_o), 32'h0);
      @(negedge clk);
      chk("R1 R2 first read strobe", 32'(mem_rd_o), 32'h1);
      chk("R1 R2 first read address", 32'(mem_addr_o), 32'h0);
      @(negedge clk);
      @(negedge clk);
      chk("R3 pc before fetch ends", 32'(pc_o), 32'h0);
      @(negedge clk);
      chk("R3 pc after fourth fetch cycle", 32'(pc_o), 32'h1);
      repeat (9) @(negedge clk);
      chk("R7 store strobe", 32'(mem_wr_o), 32'h1);
      chk("R7 R4 store address", 32'(mem_addr_o), 32'hF);
      chk("R7 store data", 32'(mem_wdata_o), 32'h5A);
      wait_halt(n);
      chk("R10 load+store+nop+halt cycles", 32'(13 + n), 32'd24);
      peek(4'hF, v);
      chk("R7 stored word", 32'(v), 32'h5A);
      chk("R5 acc after load", 32'(acc_o), 32'h5A);
      peek(4'h0, v);
      chk("R9 no-op left memory", 32'(v), 32'h5E);

      // R8: halted core is quiet and frozen
      begin
         int busy = 0;
         logic [3:0] pc_h;
         pc_h = pc_o;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_rd_o || mem_wr_o) busy++;
         end
         chk("R8 no memory traffic while halted", 32'(busy), 32'h0);
         chk("R8 pc frozen while halted", 32'(pc_o), 32'(pc_h));
         chk("R8 halted stays high", 32'(halted_o), 32'h1);
      end

      // directed: carry survives no-op and later load
      clear_prog();
      prog[0]    = 8'h5C;
      prog[1]    = 8'h2D;
      prog[2]    = 8'h7E;
      prog[3]    = 8'h5E;
      prog[4]    = 8'hF0;
      prog[4'hC] = 8'hFF;
      prog[4'hD] = 8'h02;
      prog[4'hE] = 8'h10;
      boot();
      repeat (16) @(negedge clk);
      chk("R6 wrapped add result", 32'(acc_o), 32'h01);
      chk("R6 carry out set", 32'(carry_o), 32'h1);
      repeat (5) @(negedge clk);
      chk("R9 acc after no-op", 32'(acc_o), 32'h01);
      chk("R9 carry after no-op", 32'(carry_o), 32'h1);
      chk("R9 R3 pc after no-op", 32'(pc_o), 32'h3);
      wait_halt(n);
      chk("R5 acc after second load", 32'(acc_o), 32'h10);
      chk("R5 carry kept by load", 32'(carry_o), 32'h1);
      peek(4'hE, v);
      chk("R9 no-op operand word untouched", 32'(v), 32'h10);
      peek(4'hD, v);
      chk("R11 monitor read of data word", 32'(v), 32'h02);

      // R1: reset after halt clears state
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset clears halted", 32'(halted_o), 32'h0);
      chk("R1 reset clears acc", 32'(acc_o), 32'h0);
      chk("R1 reset clears pc", 32'(pc_o), 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule